// File: doc/BRIEF.md
# Event Interrupt and Vector Unit

This block keeps the sticky event flags of a serial bus controller and turns them into one interrupt line and two DMA request lines. The transfer logic reports events through single-cycle set pulses, one per status bit. Software picks which of the five low events may raise the interrupt through an enable mask. It picks whether receive-ready and transmit-ready should drive DMA requests instead, through a separate DMA enable word.

Software services interrupts by reading a vector register. That read returns the one-based index of the lowest pending enabled event and clears that single flag in the same access, so repeated vector reads walk through the pending events in ascending order. Turning a DMA channel on removes the matching ready event from the interrupt mask. Dropping the controller enable wipes every register on the next clock edge.

Event bits in the status word: 1 no-acknowledge, 2 access ready, 3 receive ready, 4 transmit ready, 9 addressed as target, 10 transmit underflow, 11 receive overrun, 15 single byte left. Bit 12 is not stored. A status read shows the live bus-busy input there.

Top module: `evt_irq_unit`

## Requirements
- R1: `irqOut` is high in every cycle where status bits [4:0] ANDed with the 5-bit mask is nonzero, and low otherwise.
- R2: A write to select 1 loads the mask from `regWdata[4:0]`; a read of select 1 returns the mask zero-extended to 16 bits.
- R3: A read of select 3 returns the one-based position (1..5) of the lowest set bit of status[4:0] AND mask, or 0 when none is set.
- R4: A vector read with a nonzero result clears exactly that status bit at the clock edge that ends the read; a zero result clears nothing.
- R5: When a set pulse hits the same bit that a vector read clears in the same cycle, the bit stays set.
- R6: `rxDmaReq` equals status bit 3 while DMA word bit 15 is set, else 0; `txDmaReq` equals status bit 4 while DMA word bit 7 is set, else 0.
- R7: A write to select 4 keeps only bits 15 and 7 (read back at select 4); bit 15 set clears mask bit 3 and bit 7 set clears mask bit 4.
- R8: A read of select 2 returns the stored status with the live `busBusy` input at bit 12; set pulses on bit 12 are never stored.
- R9: Writes to selects 0, 2 and 3 change nothing; select 0 reads the constant 16'h0031, and selects 5 to 7 read 0.
- R10: With `ctlEnable` low, status, mask and DMA word are all 0 after the next clock edge, and set pulses in that cycle are dropped.
- R11: A stored status bit stays set until a vector read clears it or the enable drops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctlEnable | input | 1 | Controller enable; low clears all registers |
| setPulse | input | 16 | Per-bit event set pulses from transfer logic |
| busBusy | input | 1 | Live bus-busy flag, shown at status bit 12 |
| regSel | input | 3 | Register select (0 revision, 1 mask, 2 status, 3 vector, 4 DMA) |
| regWr | input | 1 | Write strobe |
| regRd | input | 1 | Read strobe; a vector read clears an event |
| regWdata | input | 16 | Write data |
| regRdata | output | 16 | Read data for the current select |
| irqOut | output | 1 | Combined interrupt |
| rxDmaReq | output | 1 | Receive DMA request |
| txDmaReq | output | 1 | Transmit DMA request |

## Verification
Random traffic mixes sparse multi-bit set pulses, random masks and DMA words, and vector reads against a bench model. This shows whether the vector picks the lowest enabled bit rather than any pending one, and whether only that bit falls. Directed cases set three events at once and read the vector twice, which separates one-based from zero-based encoding and single-bit from whole-word clearing. A set pulse that collides with a vector clear on the same bit shows set priority. A DMA write of all ones shows both field pruning and the mask side effect, and an enable drop with pulses present shows the pulses being discarded.

// File: rtl/evt_pkg.sv
package evt_pkg;
  localparam int RRDY_BIT  = 3;
  localparam int XRDY_BIT  = 4;
  localparam int BUSY_BIT  = 12;
  localparam int RXDMA_BIT = 15;
  localparam int TXDMA_BIT = 7;

  typedef enum logic [2:0] {
    SEL_REV  = 3'd0,
    SEL_MASK = 3'd1,
    SEL_STAT = 3'd2,
    SEL_VEC  = 3'd3,
    SEL_DMA  = 3'd4,
    SEL_NONE = 3'd7
  } regSel_e;

  typedef struct packed {
    logic    wrMask;
    logic    wrDma;
    logic    rdVec;
    logic    clrAll;
    regSel_e rdSel;
  } evtStrobe_t;
endpackage

// File: rtl/evt_ctrl.sv
module evt_ctrl
  import evt_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input  logic [ADDR_W-1:0] regSel,
  input  logic              regWr,
  input  logic              regRd,
  input  logic              ctlEnable,
  output evtStrobe_t        stb
);
  regSel_e selDec;

  always_comb begin
    case (int'(regSel))
      0:       selDec = SEL_REV;
      1:       selDec = SEL_MASK;
      2:       selDec = SEL_STAT;
      3:       selDec = SEL_VEC;
      4:       selDec = SEL_DMA;
      default: selDec = SEL_NONE;
    endcase
  end

  always_comb begin
    stb.rdSel  = selDec;
    stb.clrAll = !ctlEnable;
    stb.wrMask = ctlEnable && regWr && (selDec == SEL_MASK);
    stb.wrDma  = ctlEnable && regWr && (selDec == SEL_DMA);
    stb.rdVec  = ctlEnable && regRd && (selDec == SEL_VEC);
  end
endmodule

// File: rtl/evt_regs.sv
module evt_regs
  import evt_pkg::*;
#(
  parameter int          STAT_W = 16,
  parameter int          MASK_W = 5,
  parameter logic [15:0] REV_ID = 16'h0031
) (
  input  logic              clk,
  input  logic              rst_n,
  input  evtStrobe_t        stb,
  input  logic [STAT_W-1:0] wdata,
  input  logic [STAT_W-1:0] setPulse,
  input  logic              busBusy,
  output logic [STAT_W-1:0] rdata,
  output logic              irqOut,
  output logic              rxDmaReq,
  output logic              txDmaReq
);
  localparam int VEC_W = $clog2(MASK_W + 1);
  localparam logic [STAT_W-1:0] STORE_MASK = ~(STAT_W'(1) << BUSY_BIT);

  logic [STAT_W-1:0] statQ, statD, clrOne, dmaWord, busyWord;
  logic [MASK_W-1:0] maskQ, maskD, pend;
  logic              rxEnQ, txEnQ;
  logic [VEC_W-1:0]  vecIdx;
  logic              hitLow;

  assign pend = statQ[MASK_W-1:0] & maskQ;

  // lowest pending enabled event, one-based, and its one-hot clear
  always_comb begin
    vecIdx = '0;
    clrOne = '0;
    hitLow = 1'b0;
    for (int i = 0; i < MASK_W; i++) begin
      if (pend[i] && !hitLow) begin
        hitLow    = 1'b1;
        vecIdx    = VEC_W'(i + 1);
        clrOne[i] = stb.rdVec;
      end
    end
  end

  always_comb begin
    if (stb.clrAll) statD = '0;
    else            statD = (statQ & ~clrOne) | (setPulse & STORE_MASK);
  end

  always_comb begin
    maskD = maskQ;
    if (stb.clrAll) begin
      maskD = '0;
    end else if (stb.wrMask) begin
      maskD = wdata[MASK_W-1:0];
    end else if (stb.wrDma) begin
      if (wdata[RXDMA_BIT]) maskD[RRDY_BIT] = 1'b0;
      if (wdata[TXDMA_BIT]) maskD[XRDY_BIT] = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      statQ <= '0;
      maskQ <= '0;
      rxEnQ <= 1'b0;
      txEnQ <= 1'b0;
    end else begin
      statQ <= statD;
      maskQ <= maskD;
      if (stb.clrAll) begin
        rxEnQ <= 1'b0;
        txEnQ <= 1'b0;
      end else if (stb.wrDma) begin
        rxEnQ <= wdata[RXDMA_BIT];
        txEnQ <= wdata[TXDMA_BIT];
      end
    end
  end

  assign irqOut   = |pend;
  assign rxDmaReq = rxEnQ & statQ[RRDY_BIT];
  assign txDmaReq = txEnQ & statQ[XRDY_BIT];

  always_comb begin
    dmaWord            = '0;
    dmaWord[RXDMA_BIT] = rxEnQ;
    dmaWord[TXDMA_BIT] = txEnQ;
    busyWord           = '0;
    busyWord[BUSY_BIT] = busBusy;
  end

  always_comb begin
    case (stb.rdSel)
      SEL_REV:  rdata = STAT_W'(REV_ID);
      SEL_MASK: rdata = STAT_W'(maskQ);
      SEL_STAT: rdata = statQ | busyWord;
      SEL_VEC:  rdata = STAT_W'(vecIdx);
      SEL_DMA:  rdata = dmaWord;
      default:  rdata = '0;
    endcase
  end

  // R10
  disable_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stb.clrAll |=> (statQ == '0 && maskQ == '0 && !rxEnQ && !txEnQ));

  // R5
  set_sticks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!stb.clrAll && (setPulse & STORE_MASK) != '0)
      |=> ((statQ & $past(setPulse & STORE_MASK)) == $past(setPulse & STORE_MASK)));

  // R11
  no_silent_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!stb.clrAll && !stb.rdVec) |=> ((~statQ & $past(statQ)) == '0));

  // R4
  single_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!stb.clrAll && stb.rdVec && vecIdx != '0 && setPulse == '0)
      |=> ($countones(statQ) + 1 == $countones($past(statQ))));

  // R7
  dma_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!stb.clrAll && stb.wrDma && wdata[RXDMA_BIT]) |=> !maskQ[RRDY_BIT]);
endmodule

// File: rtl/evt_irq_unit.sv
module evt_irq_unit
  import evt_pkg::*;
#(
  parameter int          STAT_W = 16,
  parameter int          MASK_W = 5,
  parameter int          ADDR_W = 3,
  parameter logic [15:0] REV_ID = 16'h0031
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctlEnable,
  input  logic [STAT_W-1:0] setPulse,
  input  logic              busBusy,
  input  logic [ADDR_W-1:0] regSel,
  input  logic              regWr,
  input  logic              regRd,
  input  logic [STAT_W-1:0] regWdata,
  output logic [STAT_W-1:0] regRdata,
  output logic              irqOut,
  output logic              rxDmaReq,
  output logic              txDmaReq
);
  evtStrobe_t stb;

  evt_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .regSel   (regSel),
    .regWr    (regWr),
    .regRd    (regRd),
    .ctlEnable(ctlEnable),
    .stb      (stb)
  );

  evt_regs #(.STAT_W(STAT_W), .MASK_W(MASK_W), .REV_ID(REV_ID)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .stb     (stb),
    .wdata   (regWdata),
    .setPulse(setPulse),
    .busBusy (busBusy),
    .rdata   (regRdata),
    .irqOut  (irqOut),
    .rxDmaReq(rxDmaReq),
    .txDmaReq(txDmaReq)
  );
endmodule

// File: tb/evt_irq_unit_test.sv
`timescale 1ns/1ps
module evt_irq_unit_test;
  localparam logic [15:0] REV = 16'h0031;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ctlEnable = 1'b0;
  logic [15:0] setPulse = '0;
  logic        busBusy = 1'b0;
  logic [2:0]  regSel = '0;
  logic        regWr = 1'b0;
  logic        regRd = 1'b0;
  logic [15:0] regWdata = '0;
  logic [15:0] regRdata;
  logic        irqOut, rxDmaReq, txDmaReq;

  int total = 0;
  int bad = 0;

  logic [15:0] mStat = '0;
  logic [4:0]  mMask = '0;
  logic        mRx = 1'b0, mTx = 1'b0;

  always #10 clk = ~clk;

  evt_irq_unit uut (
    .clk(clk), .rst_n(rst_n), .ctlEnable(ctlEnable), .setPulse(setPulse),
    .busBusy(busBusy), .regSel(regSel), .regWr(regWr), .regRd(regRd),
    .regWdata(regWdata), .regRdata(regRdata), .irqOut(irqOut),
    .rxDmaReq(rxDmaReq), .txDmaReq(txDmaReq)
  );

  function automatic int expVec(logic [15:0] st, logic [4:0] mk);
    logic [4:0] p;
    p = st[4:0] & mk;
    for (int i = 0; i < 5; i++) if (p[i]) return i + 1;
    return 0;
  endfunction

  task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic step(input bit en, input int sel, input bit wr, input bit rd,
                      input logic [15:0] wd, input logic [15:0] set, input bit busy);
    int ev;
    logic [15:0] expRd;
    @(negedge clk);
    ctlEnable = en; regSel = 3'(sel); regWr = wr; regRd = rd;
    regWdata = wd; setPulse = set; busBusy = busy;
    #2;
    ev = expVec(mStat, mMask);
    check("R1 irq", 16'(irqOut), 16'(|(mStat[4:0] & mMask)));
    check("R6 rx dma", 16'(rxDmaReq), 16'(mRx & mStat[3]));
    check("R6 tx dma", 16'(txDmaReq), 16'(mTx & mStat[4]));
    if (rd) begin
      case (sel)
        0: begin expRd = REV; check("R9 revision", regRdata, expRd); end
        1: begin expRd = {11'b0, mMask}; check("R2 mask read", regRdata, expRd); end
        2: begin expRd = mStat | (16'(busy) << 12); check("R8 status read", regRdata, expRd); end
        3: begin expRd = 16'(ev); check("R3 vector", regRdata, expRd); end
        4: begin expRd = {mRx, 7'b0, mTx, 7'b0}; check("R7 dma read", regRdata, expRd); end
        default: begin expRd = '0; check("R9 unmapped read", regRdata, expRd); end
      endcase
    end
    if (!en) begin
      mStat = '0; mMask = '0; mRx = 1'b0; mTx = 1'b0;
    end else begin
      if (rd && sel == 3 && ev != 0) mStat[ev-1] = 1'b0;
      if (wr && sel == 1) mMask = wd[4:0];
      if (wr && sel == 4) begin
        mRx = wd[15]; mTx = wd[7];
        if (wd[15]) mMask[3] = 1'b0;
        if (wd[7])  mMask[4] = 1'b0;
      end
      mStat = mStat | (set & 16'hEFFF);
    end
  endtask

  initial begin
    #(20 * 200000);
    bad++; total++;
    $display("FAIL watchdog act=running exp=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // reset state
    step(1, 2, 0, 1, 16'h0, 16'h0, 0);
    check("R10 reset status", regRdata, 16'h0000);
    check("R1 reset irq", 16'(irqOut), 16'h0);

    // R2: only low 5 bits kept
    step(1, 1, 1, 0, 16'hFFFF, 16'h0, 0);
    step(1, 1, 0, 1, 16'h0, 16'h0, 0);
    check("R2 mask prune", regRdata, 16'h001F);

    // R9: ignored writes
    step(1, 2, 1, 0, 16'hFFFF, 16'h0, 0);
    step(1, 3, 1, 0, 16'hFFFF, 16'h0, 0);
    step(1, 0, 1, 0, 16'hFFFF, 16'h0, 0);
    step(1, 2, 0, 1, 16'h0, 16'h0, 0);
    check("R9 status unwritten", regRdata, 16'h0000);
    step(1, 0, 0, 1, 16'h0, 16'h0, 0);
    check("R9 revision const", regRdata, REV);

    // R3 / R4: events 1,2,4
    step(1, 0, 0, 0, 16'h0, 16'h0016, 0);
    step(1, 3, 0, 1, 16'h0, 16'h0, 0);
    check("R3 lowest vector", regRdata, 16'h0002);
    step(1, 2, 0, 1, 16'h0, 16'h0, 1);
    check("R4 single clear with R8 busy", regRdata, 16'h1014);

    // R5: set wins against vector clear
    step(1, 3, 0, 1, 16'h0, 16'h0004, 0);
    check("R5 vector before collision", regRdata, 16'h0003);
    step(1, 2, 0, 1, 16'h0, 16'h0, 0);
    check("R5 set wins", regRdata, 16'h0014);

    // R8: bit 12 pulse not stored
    step(1, 0, 0, 0, 16'h0, 16'h1000, 0);
    step(1, 2, 0, 1, 16'h0, 16'h0, 0);
    check("R8 busy not stored", regRdata, 16'h0014);

    // R7 / R6
    step(1, 4, 1, 0, 16'hFFFF, 16'h0, 0);
    step(1, 4, 0, 1, 16'h0, 16'h0, 0);
    check("R7 dma prune", regRdata, 16'h8080);
    step(1, 1, 0, 1, 16'h0, 16'h0018, 0);
    check("R7 mask side effect", regRdata, 16'h0007);
    step(1, 0, 0, 0, 16'h0, 16'h0, 0);
    check("R6 rx request", 16'(rxDmaReq), 16'h1);
    check("R6 tx request", 16'(txDmaReq), 16'h1);

    // R4: zero vector clears nothing; R11 sticky
    step(1, 1, 1, 0, 16'h0, 16'h0200, 0);
    step(1, 3, 0, 1, 16'h0, 16'h0, 0);
    check("R4 zero vector", regRdata, 16'h0000);
    repeat (4) step(1, 0, 0, 0, 16'h0, 16'h0, 0);
    step(1, 2, 0, 1, 16'h0, 16'h0, 0);
    check("R11 sticky", regRdata, 16'h021C);

    // R10: enable low with pulses present
    step(0, 0, 0, 0, 16'h0, 16'hFFFF, 0);
    step(1, 2, 0, 1, 16'h0, 16'h0, 0);
    check("R10 status cleared", regRdata, 16'h0000);
    step(1, 4, 0, 1, 16'h0, 16'h0, 0);
    check("R10 dma cleared", regRdata, 16'h0000);

    // random traffic
    for (int n = 0; n < 3000; n++) begin
      bit en, wr, rd;
      int op;
      logic [15:0] set;
      en  = ($urandom % 60) != 0;
      op  = $urandom % 3;
      wr  = (op == 1);
      rd  = (op == 2);
      set = (($urandom % 4) == 0) ? (16'($urandom) & 16'($urandom)) : 16'h0;
      step(en, $urandom % 8, wr, rd, 16'($urandom), set, 1'($urandom));
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule